// File: doc/BRIEF.md
# Large-Page Device-to-Host Address Translation Table

The block maps a fixed window of a device's address space onto host physical memory using a small table of very large pages. Each page covers 2^34 bytes (16 GiB). The window starts at device address 0x80_0000_0000 and spans as many pages as the table has entries, which is 32 by default. Each entry holds a host page number and a single attribute bit that turns bus snooping off for accesses through that page.

Software programs entries through a simple register write port. Entries sit at a four-byte stride, and a registered read port returns any entry's stored contents. A lookup port takes a full device address. On the following cycle it returns a hit or miss flag, the translated host address and the entry's no-snoop attribute. A lookup presented in the same cycle as a write to the entry it selects returns the contents from before the write.

Top module: `xlt_table`

## Requirements
- R1: While reset is held and in the first cycle after it, rspValid, rspHit, rspNoSnoop and rspHostAddr are all zero, and every entry reads back as zero.
- R2: A write with wrEn high and wrOffset bits 1:0 equal to zero programs entry wrOffset>>2. A write whose wrOffset bits 1:0 are not zero changes no entry.
- R3: Entry format: bits 31:2 hold the host page number, bit 0 is the no-snoop flag (0 = snooping on, 1 = snooping off), and bit 1 is reserved. Bit 1 is never stored and always reads back as zero.
- R4: rdData, sampled one cycle after rdOffset is presented, holds entry rdOffset>>2. Bits 1:0 of rdOffset are ignored on reads.
- R5: rspValid is high in exactly the cycles that follow a cycle with lkValid high.
- R6: The entry index is (lkAddr - 0x80_0000_0000) >> 34. A lookup hits when lkAddr is at or above 0x80_0000_0000 and that index is below the entry count.
- R7: On a hit, rspHostAddr is the entry's page number shifted left by 34, with lkAddr bits 33:0 in the low bits, and rspNoSnoop equals entry bit 0.
- R8: A lookup below 0x80_0000_0000, or at or beyond the window base plus 32 pages, returns rspHit, rspNoSnoop and rspHostAddr all zero.
- R9: A lookup in the same cycle as a write to the entry it selects returns the old contents. The next lookup of that entry returns the new contents.
- R10: In any cycle where rspValid is low, rspHit, rspNoSnoop and rspHostAddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrOffset | input | 7 | Byte offset of the entry to write |
| wrData | input | 32 | Entry value to write |
| rdOffset | input | 7 | Byte offset of the entry to read back |
| rdData | output | 32 | Registered readback of the addressed entry |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 64 | Device address to translate |
| rspValid | output | 1 | Lookup response valid, one cycle after the request |
| rspHit | output | 1 | Address fell inside the translated window |
| rspHostAddr | output | 64 | Translated host address, zero on a miss |
| rspNoSnoop | output | 1 | No-snoop attribute of the selected entry |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle request-to-response timing;
- that a hit keeps the low 34 address bits;
- that misses and idle cycles drive zeros;
- that addresses below the window base never hit;
- that the reserved bit never reads back as one.

Only the bench's scenarios can show the remaining behaviours:
- that each entry's page number lands in the right host address bits;
- that offsets with nonzero low bits leave the table untouched;
- that the upper window edge, 32 pages past the base, misses while the last page hits;
- that a write and a lookup of the same entry in one cycle return the old contents first.

The bench does this against its own reference model.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  parameter int unsigned NUM_ENTRIES_D = 32;
  parameter int unsigned PAGE_SHIFT_D  = 34;
  parameter int unsigned ADDR_W_D      = 64;
  parameter int unsigned ENTRY_W_D     = 32;
  parameter logic [63:0] WIN_BASE_D    = 64'h0000_0080_0000_0000;

  // Bit positions inside an entry (the page number fills the bits above).
  parameter int unsigned NOSNOOP_BIT = 0;
  parameter int unsigned RSV_BIT     = 1;
  parameter int unsigned PN_LSB      = 2;

  typedef struct packed {
    logic wrStb;   // accepted, aligned entry write
    logic lkStb;   // lookup presented this cycle
    logic lkHit;   // lookup address lies inside the window
  } xltStrobes_t;
endpackage

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = NUM_ENTRIES_D,
  parameter int unsigned PAGE_SHIFT  = PAGE_SHIFT_D,
  parameter int unsigned ADDR_W      = ADDR_W_D,
  parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(WIN_BASE_D),
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES),
  localparam int unsigned OFF_W = IDX_W + 2
) (
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic [OFF_W-1:0]  rdOffset,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output xltStrobes_t       strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  lkIdx
);
  localparam int unsigned SPAN_W = ADDR_W - PAGE_SHIFT;

  logic [ADDR_W-1:0] winOffset;
  logic [SPAN_W-1:0] pageSpan;
  logic              aboveBase;

  always_comb begin
    winOffset = lkAddr - WIN_BASE;
    pageSpan  = winOffset[ADDR_W-1:PAGE_SHIFT];
    aboveBase = (lkAddr >= WIN_BASE);

    strb.wrStb = wrEn && (wrOffset[1:0] == 2'b00);
    strb.lkStb = lkValid;
    strb.lkHit = lkValid && aboveBase && (pageSpan < SPAN_W'(NUM_ENTRIES));

    wrIdx = wrOffset[OFF_W-1:2];
    rdIdx = rdOffset[OFF_W-1:2];
    lkIdx = winOffset[PAGE_SHIFT +: IDX_W];
  end
endmodule

// File: rtl/xlt_datapath.sv
module xlt_datapath
  import xlt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = NUM_ENTRIES_D,
  parameter int unsigned PAGE_SHIFT  = PAGE_SHIFT_D,
  parameter int unsigned ADDR_W      = ADDR_W_D,
  parameter int unsigned ENTRY_W     = ENTRY_W_D,
  parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(WIN_BASE_D),
  localparam int unsigned IDX_W  = $clog2(NUM_ENTRIES),
  localparam int unsigned PN_W   = ENTRY_W - PN_LSB,
  localparam int unsigned HOST_W = PN_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  xltStrobes_t        strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [IDX_W-1:0]   lkIdx,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               lkValid,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic [ENTRY_W-1:0] rdData,
  output logic               rspValid,
  output logic               rspHit,
  output logic [HOST_W-1:0]  rspHostAddr,
  output logic               rspNoSnoop
);
  localparam logic [ENTRY_W-1:0] KEEP_MASK = ~(ENTRY_W'(1) << RSV_BIT);

  logic [ENTRY_W-1:0] tbl [NUM_ENTRIES];
  logic [ENTRY_W-1:0] selEntry;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        tbl[e] <= '0;
      else if (strb.wrStb && (wrIdx == IDX_W'(e)))
        tbl[e] <= wrData & KEEP_MASK;
    end
  end

  assign selEntry = tbl[lkIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspHostAddr <= '0;
      rspNoSnoop  <= 1'b0;
    end else begin
      rdData   <= tbl[rdIdx];
      rspValid <= strb.lkStb;
      if (strb.lkHit) begin
        rspHit      <= 1'b1;
        rspHostAddr <= {selEntry[ENTRY_W-1:PN_LSB], lkAddr[PAGE_SHIFT-1:0]};
        rspNoSnoop  <= selEntry[NOSNOOP_BIT];
      end else begin
        rspHit      <= 1'b0;
        rspHostAddr <= '0;
        rspNoSnoop  <= 1'b0;
      end
    end
  end

  // Response timing
  assert_rsp_follows_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  assert_rsp_has_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lkValid));

  // Page offset passes through untouched
  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspHostAddr[PAGE_SHIFT-1:0] == $past(lkAddr[PAGE_SHIFT-1:0])));

  // Misses carry zeros
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspHostAddr == '0 && !rspNoSnoop));
  assert_below_base_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && (lkAddr < WIN_BASE)) |=> !rspHit);

  // Idle outputs
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && rspHostAddr == '0 && !rspNoSnoop));

  // Reserved bit never stored
  assert_rsv_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RSV_BIT] == 1'b0);
endmodule

// File: rtl/xlt_table.sv
module xlt_table
  import xlt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = NUM_ENTRIES_D,
  parameter int unsigned PAGE_SHIFT  = PAGE_SHIFT_D,
  parameter int unsigned ADDR_W      = ADDR_W_D,
  parameter int unsigned ENTRY_W     = ENTRY_W_D,
  parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(WIN_BASE_D)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [$clog2(NUM_ENTRIES)+1:0]      wrOffset,
  input  logic [ENTRY_W-1:0]                  wrData,
  input  logic [$clog2(NUM_ENTRIES)+1:0]      rdOffset,
  output logic [ENTRY_W-1:0]                  rdData,
  input  logic                                lkValid,
  input  logic [ADDR_W-1:0]                   lkAddr,
  output logic                                rspValid,
  output logic                                rspHit,
  output logic [ENTRY_W-2+PAGE_SHIFT-1:0]     rspHostAddr,
  output logic                                rspNoSnoop
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  xltStrobes_t      strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] lkIdx;

  xlt_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .wrEn(wrEn), .wrOffset(wrOffset), .rdOffset(rdOffset),
    .lkValid(lkValid), .lkAddr(lkAddr),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .lkIdx(lkIdx)
  );

  xlt_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .WIN_BASE(WIN_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .lkIdx(lkIdx),
    .wrData(wrData), .lkValid(lkValid), .lkAddr(lkAddr),
    .rdData(rdData), .rspValid(rspValid), .rspHit(rspHit),
    .rspHostAddr(rspHostAddr), .rspNoSnoop(rspNoSnoop)
  );
endmodule

// File: tb/xlt_table_bench.sv
module xlt_table_bench;
  localparam longint unsigned BASE  = 64'h0000_0080_0000_0000;
  localparam longint unsigned PAGE  = 64'h0000_0004_0000_0000;
  localparam longint unsigned OMASK = PAGE - 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [6:0]  wrOffset;
  logic [31:0] wrData;
  logic [6:0]  rdOffset;
  logic [31:0] rdData;
  logic        lkValid;
  logic [63:0] lkAddr;
  logic        rspValid, rspHit, rspNoSnoop;
  logic [63:0] rspHostAddr;

  always #5 clk = ~clk;

  xlt_table u_xlt_table (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData),
    .rdOffset(rdOffset), .rdData(rdData), .lkValid(lkValid), .lkAddr(lkAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspHostAddr(rspHostAddr),
    .rspNoSnoop(rspNoSnoop)
  );

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit [31:0]   mdl [32];

  task automatic check(string tag, longint unsigned act, longint unsigned exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: apply inputs, predict from the model, advance, compare.
  task automatic cyc(string tag, bit we, bit [6:0] wo, bit [31:0] wd,
                     bit lk, bit [63:0] la, bit [6:0] ro);
    bit              eValid, eHit, eNs;
    longint unsigned eHost;
    bit [31:0]       eRd;
    longint unsigned span;
    wrEn = we; wrOffset = wo; wrData = wd; lkValid = lk; lkAddr = la; rdOffset = ro;
    eValid = lk; eHit = 0; eNs = 0; eHost = 0;
    eRd = mdl[ro / 4];
    if (lk && la >= BASE) begin
      span = (la - BASE) / PAGE;
      if (span < 32) begin
        eHit  = 1;
        eHost = (longint'(mdl[span] >> 2) * PAGE) + (la & OMASK);
        eNs   = mdl[span][0];
      end
    end
    if (we && (wo % 4 == 0)) mdl[wo / 4] = wd & 32'hFFFF_FFFD;
    @(posedge clk); #1;
    check(tag, rspValid, eValid, "rspValid");
    check(tag, rspHit, eHit, "rspHit");
    check(tag, rspHostAddr, eHost, "rspHostAddr");
    check(tag, rspNoSnoop, eNs, "rspNoSnoop");
    check(tag, rdData, eRd, "rdData");
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    rstN = 0; wrEn = 0; wrOffset = 0; wrData = 0; rdOffset = 0; lkValid = 0; lkAddr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    check("R1", rspValid, 0, "rspValid in reset");
    check("R1", rdData, 0, "rdData in reset");
    rstN = 1;
    // R1: entries zero after reset, lookup in window returns page 0
    for (int i = 0; i < 32; i += 7) cyc("R1", 0, 0, 0, 1, BASE + i * PAGE + 5, 7'(i * 4));

    // R2/R3: program all entries, bit1 and bit0 patterns varied
    for (int i = 0; i < 32; i++)
      cyc("R2", 1, 7'(i * 4), (32'(i) * 32'h0135_7B9D + 32'h11) ^ 32'(i % 4), 0, 0, 0);
    // R4/R3: read every entry back, reserved bit clear
    for (int i = 0; i < 32; i++) cyc("R4", 0, 0, 0, 0, 0, 7'(i * 4 + (i % 4)));

    // R6/R7: lookups across all pages with varied offsets
    for (int i = 0; i < 32; i++)
      cyc("R7", 0, 0, 0, 1, BASE + i * PAGE + ((64'(i) * 64'h0_9E37_79B9) & OMASK), 0);
    cyc("R6", 0, 0, 0, 1, BASE, 0);
    cyc("R6", 0, 0, 0, 1, BASE + 32 * PAGE - 1, 0);

    // R8: misses below, at upper edge, far beyond, extremes
    cyc("R8", 0, 0, 0, 1, BASE - 1, 0);
    cyc("R8", 0, 0, 0, 1, 0, 0);
    cyc("R8", 0, 0, 0, 1, BASE + 32 * PAGE, 0);
    cyc("R8", 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);

    // R2: unaligned writes ignored, observed through readback
    cyc("R2", 1, 7'd9, 32'hDEAD_BEEF, 0, 0, 0);
    cyc("R2", 1, 7'd126, 32'hCAFE_F00D, 0, 0, 7'd8);
    cyc("R2", 0, 0, 0, 0, 0, 7'd124);

    // R9: write and lookup of the same entry together, then lookup again
    cyc("R9", 1, 7'd20, 32'h0000_0F07, 1, BASE + 5 * PAGE + 3, 0);
    cyc("R9", 0, 0, 0, 1, BASE + 5 * PAGE + 3, 0);

    // R5/R10: back-to-back and idle gaps
    cyc("R5", 0, 0, 0, 1, BASE + 2 * PAGE, 0);
    cyc("R10", 0, 0, 0, 0, BASE + 2 * PAGE, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 1, BASE + 31 * PAGE + OMASK, 0);
    cyc("R5", 0, 0, 0, 1, BASE + 1 * PAGE, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule